// File: doc/BRIEF.md
# Guarded Nonvolatile Byte Write Controller

This block is a register-mapped control unit between a CPU bus and a small on-chip nonvolatile byte store. In this design the store is an internal register array. Software reaches three byte registers through a six-bit I/O select:

- a control register,
- a data register,
- an address register.

A byte write is guarded by a two-step sequence. Software first sets an arm bit, which is only good for a short window. Within that window it sets a go bit. The write then runs as a busy period whose length is a parameter. The CPU is stalled for two cycles when the write starts.

Reads are one cycle long. A level interrupt reports that the unit is ready. The address and data used by a write are captured at its start, so software may prepare the next byte while the current one is still being stored.

Top module: `nvbyte_guard_ctrl`

## Requirements
- R1: After reset the control, data and address registers all read 0, `cpu_stall` is 0 and `ready_irq` is 0.
- R2: The select values are 0x1C for control, 0x1D for data and 0x1E for the 7-bit address register. Control bit 3 is the interrupt enable, bit 2 is arm, bit 1 is go/busy and bit 0 is fetch. Control bits 7..4 and address bit 7 always read 0. Every control write loads bit 3 from the written value.
- R3: Writing 1 to arm sets it, and hardware clears it at the fourth clock edge after the setting edge. Writing 0 to arm while it is set has no effect.
- R4: Writing 1 to go starts a write only if arm is 1 at that clock edge. Otherwise go stays 0 and nothing is stored.
- R5: After a write starts, go reads 1 for exactly ACCESS_CYCLES cycles and then reads 0. The data byte is then held at the address.
- R6: `cpu_stall` is 1 for exactly the two cycles that follow the edge that starts a write, and 0 otherwise.
- R7: `ready_irq` is a level equal to interrupt-enable AND `glb_irq_en` AND NOT busy.
- R8: Writing 1 to fetch while idle loads the data register with the byte at the current address at that edge. The fetch bit reads 1 for one cycle and then clears.
- R9: A fetch request made while busy is ignored, and the data register keeps its value.
- R10: Address and data register writes made during a busy period are accepted. They do not change the byte being written or its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 6 | I/O register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| glb_irq_en | input | 1 | Global interrupt flag from the CPU |
| cpu_stall | output | 1 | CPU hold request at write start |
| ready_irq | output | 1 | Level ready interrupt |

## Verification
The bench builds the block with ACCESS_CYCLES set to 20 and keeps the default four-cycle arm window and 128-byte store. A 20-cycle busy period lets the bench count every busy cycle exactly. It also leaves room, inside one busy period, for address, data and fetch accesses while a write is in flight. The four-cycle window is probed at both edges: a go on the last armed edge starts a write, and a go one edge later does not.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
    localparam int CTRL_IE    = 3;
    localparam int CTRL_ARM   = 2;
    localparam int CTRL_GO    = 1;
    localparam int CTRL_FETCH = 0;

    // Visible low nibble of the control register, bit 3 down to bit 0.
    typedef struct packed {
        logic irq_en;
        logic arm;
        logic busy;
        logic fetch;
    } ctrl_view_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_DATA,
        SEL_ADDR
    } reg_sel_e;

    function automatic logic [7:0] pack_ctrl(input ctrl_view_t v);
        return {4'b0000, v};
    endfunction
endpackage

// File: rtl/nvg_arm_window.sv
module nvg_arm_window #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    output logic armed
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            left_q <= '0;
        end else if (set_req) begin
            armed  <= 1'b1;
            left_q <= CW'(WINDOW - 1);
        end else if (armed) begin
            if (left_q == '0) armed <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    // R3: an armed window whose count is spent closes at the next edge unless re-armed
    a_r3_window_closes: assert property (@(posedge clk) disable iff (rst)
        armed && left_q == '0 && !set_req |=> !armed);
endmodule

// File: rtl/nvg_write_timer.sv
module nvg_write_timer #(
    parameter int ACCESS = 20,
    parameter int STALL  = 2,
    parameter int AW     = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] addr_in,
    input  logic [7:0]    data_in,
    output logic          busy,
    output logic          stall,
    output logic          commit,
    output logic [AW-1:0] commit_addr,
    output logic [7:0]    commit_data
);
    localparam int CW = $clog2(ACCESS + 1);
    localparam int SW = $clog2(STALL + 1);

    logic [CW-1:0] cnt_q;
    logic [SW-1:0] stall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            cnt_q       <= '0;
            stall_q     <= '0;
            commit_addr <= '0;
            commit_data <= '0;
        end else begin
            if (start && !busy) begin
                busy        <= 1'b1;
                cnt_q       <= CW'(ACCESS - 1);
                stall_q     <= SW'(STALL);
                commit_addr <= addr_in;
                commit_data <= data_in;
            end else begin
                if (busy) begin
                    if (cnt_q == '0) busy <= 1'b0;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                if (stall_q != '0) stall_q <= stall_q - 1'b1;
            end
        end
    end

    assign stall  = (stall_q != '0);
    assign commit = busy && (cnt_q == '0);

    // R5: the last busy cycle is followed by idle
    a_r5_busy_ends: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy);
    // R6: the stall never outlives the write
    a_r6_stall_in_busy: assert property (@(posedge clk) disable iff (rst)
        stall |-> busy);
    // R10: latched target is frozen while the write runs
    a_r10_latch_frozen: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(commit_addr) && $stable(commit_data));
endmodule

// File: rtl/nvg_byte_array.sv
module nvg_byte_array #(
    parameter int DEPTH = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvbyte_guard_ctrl.sv
module nvbyte_guard_ctrl
    import nvg_pkg::*;
#(
    parameter int          DEPTH         = 128,
    parameter int          ACCESS_CYCLES = 66400,
    parameter int          ARM_CYCLES    = 4,
    parameter logic [5:0]  CTRL_SEL      = 6'h1C,
    parameter logic [5:0]  DATA_SEL      = 6'h1D,
    parameter logic [5:0]  ADDR_SEL      = 6'h1E
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [5:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       glb_irq_en,
    output logic       cpu_stall,
    output logic       ready_irq
);
    localparam int AW = $clog2(DEPTH);

    reg_sel_e      sel;
    logic          ctrl_wr, set_req, go_req, start, fetch_req;
    logic          armed, busy, commit;
    logic          irq_en_q, fetch_q;
    logic [AW-1:0] addr_q, commit_addr;
    logic [7:0]    data_q, commit_data, cell_rd;
    ctrl_view_t    view;

    always_comb begin
        if      (bus_sel == CTRL_SEL) sel = SEL_CTRL;
        else if (bus_sel == DATA_SEL) sel = SEL_DATA;
        else if (bus_sel == ADDR_SEL) sel = SEL_ADDR;
        else                          sel = SEL_NONE;
    end

    assign ctrl_wr   = bus_wr && (sel == SEL_CTRL);
    assign set_req   = ctrl_wr && bus_wdata[CTRL_ARM];
    assign go_req    = ctrl_wr && bus_wdata[CTRL_GO];
    assign start     = go_req && armed && !busy;
    assign fetch_req = ctrl_wr && bus_wdata[CTRL_FETCH] && !busy;

    nvg_arm_window #(.WINDOW(ARM_CYCLES)) u_arm (
        .clk(clk), .rst(rst), .set_req(set_req), .armed(armed)
    );

    nvg_write_timer #(.ACCESS(ACCESS_CYCLES), .STALL(2), .AW(AW)) u_timer (
        .clk(clk), .rst(rst), .start(start),
        .addr_in(addr_q), .data_in(data_q),
        .busy(busy), .stall(cpu_stall), .commit(commit),
        .commit_addr(commit_addr), .commit_data(commit_data)
    );

    nvg_byte_array #(.DEPTH(DEPTH), .AW(AW)) u_cells (
        .clk(clk), .we(commit), .waddr(commit_addr), .wdata(commit_data),
        .raddr(addr_q), .rdata(cell_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en_q <= 1'b0;
            fetch_q  <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
        end else begin
            if (ctrl_wr) irq_en_q <= bus_wdata[CTRL_IE];
            fetch_q <= fetch_req;
            if (bus_wr && sel == SEL_ADDR) addr_q <= bus_wdata[AW-1:0];
            if (fetch_req)                      data_q <= cell_rd;
            else if (bus_wr && sel == SEL_DATA) data_q <= bus_wdata;
        end
    end

    assign view = '{irq_en: irq_en_q, arm: armed, busy: busy, fetch: fetch_q};

    always_comb begin
        case (sel)
            SEL_CTRL: bus_rdata = pack_ctrl(view);
            SEL_DATA: bus_rdata = data_q;
            SEL_ADDR: bus_rdata = 8'(addr_q);
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign ready_irq = irq_en_q && glb_irq_en && !busy;

    // R3: arm only rises after a software set
    a_r3_arm_from_set: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(set_req));
    // R4: a write only begins from an armed state
    a_r4_start_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(armed));
    // R6: the stall accompanies every write start
    a_r6_stall_on_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> cpu_stall);
    // R7: no ready interrupt while a write runs
    a_r7_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ready_irq);
    // R9: a fetch only completes from idle
    a_r9_fetch_from_idle: assert property (@(posedge clk) disable iff (rst)
        fetch_q |-> !$past(busy));
endmodule

// File: tb/nvbyte_guard_ctrl_test.sv
module nvbyte_guard_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int ACC = 20;
    localparam logic [5:0] S_CTRL = 6'h1C, S_DATA = 6'h1D, S_ADDR = 6'h1E;

    logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, glb_irq_en = 1'b0;
    logic [5:0] bus_sel = 6'h00;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic cpu_stall, ready_irq;
    logic ie_sh = 1'b0;
    int total = 0, failed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvbyte_guard_ctrl #(.ACCESS_CYCLES(ACC)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glb_irq_en(glb_irq_en),
        .cpu_stall(cpu_stall), .ready_irq(ready_irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [5:0] s, input logic [7:0] v);
        bus_sel = s; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ctl(input logic [7:0] bits);
        wr(S_CTRL, bits | {4'b0, ie_sh, 3'b000});
    endtask

    task automatic peek(input logic [5:0] s, output logic [7:0] v);
        bus_sel = s; #1; v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        logic [7:0] v;
        for (int i = 0; i < 200; i++) begin
            peek(S_CTRL, v);
            if (!v[1]) break;
            idle(1);
        end
    endtask

    task automatic store(input logic [6:0] a, input logic [7:0] d);
        wr(S_ADDR, {1'b0, a}); wr(S_DATA, d);
        ctl(8'h04); ctl(8'h02);
        wait_done();
    endtask

    task automatic fetch(input logic [6:0] a, output logic [7:0] d);
        wr(S_ADDR, {1'b0, a}); ctl(8'h01);
        peek(S_DATA, d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(S_CTRL, v); chk("R1 ctrl after reset", v, 8'h00);
        peek(S_DATA, v); chk("R1 data after reset", v, 8'h00);
        peek(S_ADDR, v); chk("R1 addr after reset", v, 8'h00);
        chk("R1 stall after reset", {7'b0, cpu_stall}, 8'h00);
        chk("R1 irq after reset", {7'b0, ready_irq}, 8'h00);
    endtask

    task automatic t_layout();
        logic [7:0] v;
        wr(S_CTRL, 8'hF0); peek(S_CTRL, v); chk("R2 upper ctrl bits read zero", v, 8'h00);
        wr(S_CTRL, 8'h08); peek(S_CTRL, v); chk("R2 irq enable at bit 3", v, 8'h08);
        wr(S_CTRL, 8'h00);
        wr(S_ADDR, 8'hFF); peek(S_ADDR, v); chk("R2 addr bit 7 reads zero", v, 8'h7F);
    endtask

    task automatic t_arm_window();
        logic [7:0] v;
        ctl(8'h04); peek(S_CTRL, v); chk("R3 arm set", v & 8'h04, 8'h04);
        idle(3); peek(S_CTRL, v); chk("R3 arm held 4th cycle", v & 8'h04, 8'h04);
        idle(1); peek(S_CTRL, v); chk("R3 arm cleared after 4", v & 8'h04, 8'h00);
        ctl(8'h04); ctl(8'h00); peek(S_CTRL, v); chk("R3 writing 0 keeps arm", v & 8'h04, 8'h04);
        idle(4);
    endtask

    task automatic t_go_guard();
        logic [7:0] v;
        ctl(8'h02); peek(S_CTRL, v); chk("R4 go without arm ignored", v & 8'h02, 8'h00);
        chk("R4 no stall without arm", {7'b0, cpu_stall}, 8'h00);
        ctl(8'h04); idle(4); ctl(8'h02); peek(S_CTRL, v);
        chk("R4 go after window ignored", v & 8'h02, 8'h00);
        chk("R4 no stall late go", {7'b0, cpu_stall}, 8'h00);
    endtask

    task automatic t_write_timing();
        logic [7:0] v;
        int n = 0;
        wr(S_ADDR, 8'h05); wr(S_DATA, 8'hA5);
        ctl(8'h04); idle(3); ctl(8'h02);   // go on the last armed edge
        peek(S_CTRL, v); chk("R4 go on last armed edge starts", v & 8'h02, 8'h02);
        while (v[1] && n < 100) begin
            chk($sformatf("R6 stall busy cycle %0d", n), {7'b0, cpu_stall}, {7'b0, n < 2});
            n++; idle(1); peek(S_CTRL, v);
        end
        chk("R5 busy length", 8'(n), 8'(ACC));
        wr(S_DATA, 8'h00);
        fetch(7'd5, v); chk("R5 byte stored", v, 8'hA5);
        chk("R8 fetch loads data", v, 8'hA5);
        peek(S_CTRL, v); chk("R8 fetch bit one cycle", v & 8'h01, 8'h01);
        idle(1); peek(S_CTRL, v); chk("R8 fetch bit clears", v & 8'h01, 8'h00);
    endtask

    task automatic t_busy_updates();
        logic [7:0] v;
        store(7'd10, 8'h11);
        wr(S_ADDR, 8'h09); wr(S_DATA, 8'h3C);
        ctl(8'h04); ctl(8'h02);
        wr(S_ADDR, 8'h0A); wr(S_DATA, 8'hFF);
        peek(S_ADDR, v); chk("R10 addr accepted while busy", v, 8'h0A);
        ctl(8'h01); peek(S_DATA, v); chk("R9 fetch while busy ignored", v, 8'hFF);
        peek(S_CTRL, v); chk("R9 fetch bit stays 0 while busy", v & 8'h01, 8'h00);
        wait_done();
        fetch(7'd9, v);  chk("R10 latched data at latched addr", v, 8'h3C);
        fetch(7'd10, v); chk("R10 other addr untouched", v, 8'h11);
    endtask

    task automatic t_irq();
        ie_sh = 1'b1; ctl(8'h00); glb_irq_en = 1'b0; #1;
        chk("R7 irq needs global flag", {7'b0, ready_irq}, 8'h00);
        glb_irq_en = 1'b1; #1;
        chk("R7 irq level when idle", {7'b0, ready_irq}, 8'h01);
        idle(2);
        chk("R7 irq stays high", {7'b0, ready_irq}, 8'h01);
        ctl(8'h04); ctl(8'h02);
        chk("R7 irq low while busy", {7'b0, ready_irq}, 8'h00);
        wait_done();
        chk("R7 irq back after write", {7'b0, ready_irq}, 8'h01);
        ie_sh = 1'b0; ctl(8'h00);
        chk("R7 irq off with enable clear", {7'b0, ready_irq}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failed++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        idle(3); rst = 1'b0;
        t_reset();
        t_layout();
        t_arm_window();
        t_go_guard();
        t_write_timing();
        t_busy_updates();
        t_irq();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule